// File: doc/BRIEF.md
# Wide-Instruction Bundle Execution Core

This core executes a program of 64-bit bundles, one bundle per logical step. One bundle can carry two loads, an integer add, an integer multiply, a store, an add-immediate and a counted-loop branch. Every slot sees the register file as it was when the bundle began. All of the bundle's writes land together when the bundle ends. A compiler can therefore pack work from different iterations of a loop into one word. A prologue fills the registers, a one-bundle steady state repeats, and an epilogue empties them.

The three memory slots share one data port. A small sequencer issues them one after another in a fixed order, waits for each load response, and then commits the bundle. Integer arithmetic stands in for floating point. A start pulse runs the program from bundle address 0, and done rises when the core fetches an all-zero bundle.

Top module: `bundle_core`

## Requirements
- R1: The bundle layout is as follows, in bits. [63] loop enable. [62:55] 8-bit immediate, shared by the add-immediate stride and the loop target. [54:51] add-immediate register. [50:47] store data register, [46:43] store pointer, [42] store post-increment. [41:38] multiply destination, [37:34] and [33:30] multiply sources. [29:26] add destination, [25:22] and [21:18] add sources. [17:14] second-load destination, [13:10] its pointer, [9] its post-increment. [8:5] first-load destination, [4:1] its pointer, [0] its post-increment.
- R2: Register 0 reads as zero. A load, add, multiply or add-immediate whose destination is register 0 is disabled, and so is a store whose pointer is register 0. An all-zero bundle halts the core: done goes high and stays high, with no memory request, until start is pulsed. The pulse restarts the core at bundle address 0.
- R3: Every source operand in a bundle, including pointers and store data, takes the register value from before the bundle began.
- R4: A value written by a bundle is first seen as an operand by the next bundle.
- R5: Post-increment adds one to a pointer register. When several slots write the same register, the result is taken in this order, highest first: first load, second load, add, multiply, add-immediate, post-increment.
- R6: The add-immediate slot adds the sign-extended 8-bit immediate to its register. With register 0 and the loop disabled, it adds the immediate to the loop count instead.
- R7: The loop slot decrements the loop count. If the new count is not zero, the next bundle is fetched from the immediate; otherwise the next bundle is fetched from the following address.
- R8: Memory requests go out one per cycle in the order first load, second load, store, and only for enabled slots. Read data returns with the response-valid flag, and the core raises no new request in the cycle after a load request.
- R9: When a load and a store in one bundle use the same address, the load returns the value stored before the bundle.
- R10: A software-pipelined vector add leaves the element-wise sums in place. It uses a prologue, a one-bundle steady state run N-2 times, and an epilogue. It reads each source element exactly once and writes nothing past the array.
- R11: After reset, done is low, no memory request is raised and the fetch address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that runs the program from address 0 |
| done | output | 1 | High while halted after an all-zero bundle |
| imemAddr | output | PC_W | Bundle fetch address |
| imemData | input | 64 | Bundle at imemAddr, combinational |
| dmemReq | output | 1 | Data memory request |
| dmemWe | output | 1 | Request is a write |
| dmemAddr | output | ADDR_W | Data memory word address |
| dmemWdata | output | DATA_W | Write data |
| dmemRvalid | input | 1 | Read response valid |
| dmemRdata | input | DATA_W | Read response data |

## Verification
The bench builds the core with its defaults: 16-bit data, 8-bit bundle addresses and 8-bit data addresses. With 16-bit data, a negative 8-bit stride is visibly sign-extended, and a product such as 35 fits without wrapping. The 8-bit addresses let two source arrays, a result area and a run-past sentinel sit in one 256-word memory. A logged request trace confirms the port order and the request count of each bundle.

// File: rtl/bundle_pkg.sv
`timescale 1ns/1ps
package bundle_pkg;
  localparam int RIDX_W = 4;
  localparam int IMM_W  = 8;

  // Fixed 64-bit bundle layout, MSB first.
  typedef struct packed {
    logic              loopEn;
    logic [IMM_W-1:0]  imm;
    logic [RIDX_W-1:0] iaddReg;
    logic [RIDX_W-1:0] stSrc;
    logic [RIDX_W-1:0] stPtr;
    logic              stInc;
    logic [RIDX_W-1:0] mulDst;
    logic [RIDX_W-1:0] mulA;
    logic [RIDX_W-1:0] mulB;
    logic [RIDX_W-1:0] addDst;
    logic [RIDX_W-1:0] addA;
    logic [RIDX_W-1:0] addB;
    logic [RIDX_W-1:0] ld1Dst;
    logic [RIDX_W-1:0] ld1Ptr;
    logic              ld1Inc;
    logic [RIDX_W-1:0] ld0Dst;
    logic [RIDX_W-1:0] ld0Ptr;
    logic              ld0Inc;
  } bundle_t;

  localparam int BUNDLE_W = $bits(bundle_t);

  typedef enum logic [1:0] {MS_LD0, MS_LD1, MS_ST} memSlot_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic     restart;
    logic     fetch;
    logic     memReq;
    logic     memWe;
    memSlot_e slot;
    logic     capLd0;
    logic     capLd1;
    logic     commit;
  } strobe_t;
endpackage

// File: rtl/bundle_ctrl.sv
`timescale 1ns/1ps
module bundle_ctrl
  import bundle_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  bundle_t fetched,
  input  logic    memRvalid,
  output strobe_t stb,
  output logic    done
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_LD0, S_W0, S_LD1, S_W1, S_ST, S_COMMIT, S_HALT
  } state_e;

  state_e     state, stateNext;
  logic [2:0] pend, pendNext, fetchMask;

  // bit0 first load, bit1 second load, bit2 store
  assign fetchMask = {fetched.stPtr != '0, fetched.ld1Dst != '0, fetched.ld0Dst != '0};

  function automatic state_e firstSlot(input logic [2:0] m);
    if (m[0])      return S_LD0;
    else if (m[1]) return S_LD1;
    else if (m[2]) return S_ST;
    else           return S_COMMIT;
  endfunction

  always_comb begin
    stateNext = state;
    pendNext  = pend;
    stb       = '0;
    stb.slot  = MS_LD0;
    unique case (state)
      S_IDLE, S_HALT: begin
        if (start) begin
          stb.restart = 1'b1;
          stateNext   = S_FETCH;
        end
      end
      S_FETCH: begin
        stb.fetch = 1'b1;
        if (fetched == '0) begin
          stateNext = S_HALT;
        end else begin
          pendNext  = fetchMask;
          stateNext = firstSlot(fetchMask);
        end
      end
      S_LD0: begin
        stb.memReq  = 1'b1;
        stb.slot    = MS_LD0;
        pendNext[0] = 1'b0;
        stateNext   = S_W0;
      end
      S_W0: begin
        if (memRvalid) begin
          stb.capLd0 = 1'b1;
          stateNext  = firstSlot(pend);
        end
      end
      S_LD1: begin
        stb.memReq  = 1'b1;
        stb.slot    = MS_LD1;
        pendNext[1] = 1'b0;
        stateNext   = S_W1;
      end
      S_W1: begin
        if (memRvalid) begin
          stb.capLd1 = 1'b1;
          stateNext  = firstSlot(pend);
        end
      end
      S_ST: begin
        stb.memReq  = 1'b1;
        stb.memWe   = 1'b1;
        stb.slot    = MS_ST;
        pendNext[2] = 1'b0;
        stateNext   = S_COMMIT;
      end
      S_COMMIT: begin
        stb.commit = 1'b1;
        stateNext  = S_FETCH;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      pend  <= '0;
    end else begin
      state <= stateNext;
      pend  <= pendNext;
    end
  end

  assign done = (state == S_HALT);
endmodule

// File: rtl/bundle_dpath.sv
`timescale 1ns/1ps
module bundle_dpath
  import bundle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  bundle_t           fetched,
  input  logic [DATA_W-1:0] memRdata,
  output logic [PC_W-1:0]   pc,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam int NREG = 1 << RIDX_W;

  logic [DATA_W-1:0] regFile [NREG];
  logic [DATA_W-1:0] regNext [NREG];
  logic [DATA_W-1:0] srcVal  [NREG];
  bundle_t           ir;
  logic [DATA_W-1:0] loopCnt, loopCntNext, ld0Val, ld1Val, immExt;
  logic [PC_W-1:0]   pcNext;
  logic              ld0On, ld1On, stOn;

  // Register 0 reads as zero.
  for (genvar g = 0; g < NREG; g++) begin : g_src
    if (g == 0) begin : g_zero
      assign srcVal[g] = '0;
    end else begin : g_reg
      assign srcVal[g] = regFile[g];
    end
  end

  assign ld0On  = ir.ld0Dst != '0;
  assign ld1On  = ir.ld1Dst != '0;
  assign stOn   = ir.stPtr != '0;
  assign immExt = {{(DATA_W-IMM_W){ir.imm[IMM_W-1]}}, ir.imm};

  always_comb begin
    unique case (stb.slot)
      MS_LD0:  memAddr = ADDR_W'(srcVal[ir.ld0Ptr]);
      MS_LD1:  memAddr = ADDR_W'(srcVal[ir.ld1Ptr]);
      MS_ST:   memAddr = ADDR_W'(srcVal[ir.stPtr]);
      default: memAddr = '0;
    endcase
  end
  assign memWdata = srcVal[ir.stSrc];

  // Later assignments win: increments < add-immediate < mul < add < loads.
  always_comb begin
    for (int i = 0; i < NREG; i++) regNext[i] = regFile[i];
    if (stOn && ir.stInc)   regNext[ir.stPtr]  = srcVal[ir.stPtr] + DATA_W'(1);
    if (ld1On && ir.ld1Inc) regNext[ir.ld1Ptr] = srcVal[ir.ld1Ptr] + DATA_W'(1);
    if (ld0On && ir.ld0Inc) regNext[ir.ld0Ptr] = srcVal[ir.ld0Ptr] + DATA_W'(1);
    if (ir.iaddReg != '0)   regNext[ir.iaddReg] = srcVal[ir.iaddReg] + immExt;
    if (ir.mulDst != '0)    regNext[ir.mulDst] = srcVal[ir.mulA] * srcVal[ir.mulB];
    if (ir.addDst != '0)    regNext[ir.addDst] = srcVal[ir.addA] + srcVal[ir.addB];
    if (ld1On)              regNext[ir.ld1Dst] = ld1Val;
    if (ld0On)              regNext[ir.ld0Dst] = ld0Val;
  end

  always_comb begin
    loopCntNext = loopCnt;
    pcNext      = pc + PC_W'(1);
    if (ir.loopEn) begin
      loopCntNext = loopCnt - DATA_W'(1);
      if (loopCntNext != '0) pcNext = PC_W'(ir.imm);
    end else if (ir.iaddReg == '0) begin
      loopCntNext = loopCnt + immExt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
      ir      <= '0;
      pc      <= '0;
      loopCnt <= '0;
      ld0Val  <= '0;
      ld1Val  <= '0;
    end else begin
      if (stb.fetch)  ir     <= fetched;
      if (stb.capLd0) ld0Val <= memRdata;
      if (stb.capLd1) ld1Val <= memRdata;
      if (stb.restart) begin
        pc <= '0;
      end else if (stb.commit) begin
        pc      <= pcNext;
        loopCnt <= loopCntNext;
        for (int i = 0; i < NREG; i++) regFile[i] <= regNext[i];
      end
    end
  end
endmodule

// File: rtl/bundle_core.sv
`timescale 1ns/1ps
module bundle_core
  import bundle_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 8,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                done,
  output logic [PC_W-1:0]     imemAddr,
  input  logic [BUNDLE_W-1:0] imemData,
  output logic                dmemReq,
  output logic                dmemWe,
  output logic [ADDR_W-1:0]   dmemAddr,
  output logic [DATA_W-1:0]   dmemWdata,
  input  logic                dmemRvalid,
  input  logic [DATA_W-1:0]   dmemRdata
);
  strobe_t stb;
  bundle_t fetchWord;

  assign fetchWord = bundle_t'(imemData);
  assign dmemReq   = stb.memReq;
  assign dmemWe    = stb.memWe;

  bundle_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .fetched   (fetchWord),
    .memRvalid (dmemRvalid),
    .stb       (stb),
    .done      (done)
  );

  bundle_dpath #(.DATA_W(DATA_W), .PC_W(PC_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .fetched  (fetchWord),
    .memRdata (dmemRdata),
    .pc       (imemAddr),
    .memAddr  (dmemAddr),
    .memWdata (dmemWdata)
  );
endmodule

// File: rtl/bundle_core_chk.sv
`timescale 1ns/1ps
module bundle_core_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            done,
  input logic [PC_W-1:0] imemAddr,
  input logic            dmemReq,
  input logic            dmemWe
);
  // R8: a write is always part of a request
  p_we_needs_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    dmemWe |-> dmemReq);

  // R8: a load request is followed by a cycle without request
  p_load_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dmemReq && !dmemWe) |=> !dmemReq);

  // R2: a halted core raises no memory request
  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !dmemReq);

  // R2: halt persists until start
  p_halt_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R4: the fetch address only moves once the bundle's memory work is over
  p_pc_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    dmemReq |=> $stable(imemAddr));
endmodule

bind bundle_core bundle_core_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .done     (done),
  .imemAddr (imemAddr),
  .dmemReq  (dmemReq),
  .dmemWe   (dmemWe)
);

// File: tb/bundle_core_test.sv
`timescale 1ns/1ps
module bundle_core_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        done;
  logic [7:0]  imemAddr;
  logic [63:0] imemData;
  logic        dmemReq, dmemWe;
  logic [7:0]  dmemAddr;
  logic [15:0] dmemWdata;
  logic        dmemRvalid = 1'b0;
  logic [15:0] dmemRdata = '0;

  logic [63:0] rom [256];
  logic [15:0] ram [256];
  logic        tbWe = 1'b0;
  logic [7:0]  tbAddr = '0;
  logic [15:0] tbData = '0;
  logic        logClr = 1'b1;
  int          logN = 0;
  logic        logWe [64];
  logic [7:0]  logAd [64];
  int          nChecks = 0;
  int          nFail = 0;

  always #10 clk = ~clk;

  bundle_core uut (
    .clk(clk), .rstN(rstN), .start(start), .done(done),
    .imemAddr(imemAddr), .imemData(imemData),
    .dmemReq(dmemReq), .dmemWe(dmemWe), .dmemAddr(dmemAddr),
    .dmemWdata(dmemWdata), .dmemRvalid(dmemRvalid), .dmemRdata(dmemRdata)
  );

  assign imemData = rom[imemAddr];

  // Single-port synchronous RAM with one-cycle read response, plus request trace.
  always @(posedge clk) begin
    dmemRvalid <= dmemReq && !dmemWe;
    if (dmemReq) begin
      if (dmemWe) ram[dmemAddr] <= dmemWdata;
      dmemRdata <= ram[dmemAddr];
    end else if (tbWe) begin
      ram[tbAddr] <= tbData;
    end
    if (logClr) logN <= 0;
    else if (dmemReq && logN < 64) begin
      logWe[logN] <= dmemWe;
      logAd[logN] <= dmemAddr;
      logN <= logN + 1;
    end
  end

  // Field builders following the R1 layout; fields are disjoint, so they OR together.
  function automatic logic [63:0] ld0B(input logic [3:0] d, input logic [3:0] p, input logic i);
    return 64'({d, p, i});
  endfunction
  function automatic logic [63:0] ld1B(input logic [3:0] d, input logic [3:0] p, input logic i);
    return 64'({d, p, i}) << 9;
  endfunction
  function automatic logic [63:0] addB(input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
    return 64'({d, a, b}) << 18;
  endfunction
  function automatic logic [63:0] mulB(input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
    return 64'({d, a, b}) << 30;
  endfunction
  function automatic logic [63:0] stB(input logic [3:0] s, input logic [3:0] p, input logic i);
    return 64'({s, p, i}) << 42;
  endfunction
  function automatic logic [63:0] iaddB(input logic [3:0] r, input logic [7:0] imm);
    return (64'(r) << 51) | (64'(imm) << 55);
  endfunction
  function automatic logic [63:0] loopB(input logic [7:0] tgt);
    return (64'(1) << 63) | (64'(tgt) << 55);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    logClr = 1'b1;
    for (int i = 0; i < 256; i++) rom[i] = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    logClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = a; tbData = v;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic runProg(input string req);
    int waitCyc = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    chk(req, "program reached halt", 32'(done), 1);
  endtask

  task automatic testReset();
    doReset();
    chk("R11", "done after reset", 32'(done), 0);
    chk("R11", "no request after reset", 32'(dmemReq), 0);
    chk("R11", "fetch address after reset", 32'(imemAddr), 0);
  endtask

  task automatic testParallel();
    doReset();
    rom[0] = iaddB(1, 8'd5);
    rom[1] = iaddB(2, 8'd7);
    rom[2] = iaddB(9, 8'd40);
    rom[3] = addB(3, 1, 2) | mulB(1, 1, 2) | iaddB(2, 8'd1) | ld0B(0, 1, 1);
    rom[4] = addB(4, 1, 2) | stB(3, 9, 1);
    rom[5] = stB(4, 9, 1);
    rom[6] = stB(1, 9, 1);
    rom[7] = stB(2, 9, 1);
    runProg("R1");
    chk("R3", "add sees pre-bundle sources", 32'(ram[40]), 12);
    chk("R4", "next bundle sees committed values", 32'(ram[41]), 43);
    chk("R3", "multiply from old sources", 32'(ram[42]), 35);
    chk("R6", "add-immediate result", 32'(ram[43]), 8);
    chk("R2", "disabled load issues no request", 32'(logN), 4);
  endtask

  task automatic testLoadAdd();
    doReset();
    poke(8'd60, 16'd100);
    poke(8'd61, 16'd200);
    rom[0] = iaddB(1, 8'd60);
    rom[1] = iaddB(4, 8'd3);
    rom[2] = iaddB(10, 8'd80);
    rom[3] = ld0B(4, 1, 1) | addB(5, 4, 4);
    rom[4] = ld0B(1, 1, 1);
    rom[5] = stB(4, 10, 1);
    rom[6] = stB(5, 10, 1);
    rom[7] = stB(1, 10, 1);
    rom[8] = iaddB(10, 8'd5);
    rom[9] = iaddB(10, 8'hFC);
    rom[10] = stB(4, 10, 0);
    runProg("R3");
    chk("R3", "load destination gets loaded value", 32'(ram[80]), 100);
    chk("R3", "add used old destination value", 32'(ram[81]), 6);
    chk("R5", "load beats post-increment, pointer was incremented", 32'(ram[82]), 200);
    chk("R6", "negative immediate is sign-extended", 32'(ram[84]), 100);
  endtask

  task automatic testMemOrder();
    doReset();
    poke(8'd100, 16'd11);
    poke(8'd101, 16'd22);
    rom[0] = iaddB(1, 8'd100);
    rom[1] = iaddB(2, 8'd101);
    rom[2] = iaddB(3, 8'd7);
    rom[3] = iaddB(12, 8'd90);
    rom[4] = ld0B(5, 1, 0) | ld1B(6, 2, 0) | stB(3, 1, 0);
    rom[5] = stB(5, 12, 1);
    rom[6] = stB(6, 12, 1);
    runProg("R8");
    chk("R9", "load sees value before same-address store", 32'(ram[90]), 11);
    chk("R9", "store landed", 32'(ram[100]), 7);
    chk("R8", "second load value", 32'(ram[91]), 22);
    chk("R8", "request count", 32'(logN), 5);
    chk("R8", "first request is a load", 32'(logWe[0]), 0);
    chk("R8", "first request address", 32'(logAd[0]), 100);
    chk("R8", "second request address", 32'(logAd[1]), 101);
    chk("R8", "third request is the store", 32'(logWe[2]), 1);
  endtask

  task automatic testLoop();
    doReset();
    rom[0] = iaddB(0, 8'd5);
    rom[1] = iaddB(7, 8'd70);
    rom[2] = iaddB(1, 8'd2) | loopB(8'd2);
    rom[3] = stB(1, 7, 1);
    rom[4] = iaddB(0, 8'd1);
    rom[5] = iaddB(1, 8'd5) | loopB(8'd5);
    rom[6] = stB(1, 7, 0);
    runProg("R7");
    chk("R7", "loop body ran count times", 32'(ram[70]), 10);
    chk("R7", "count of one falls through once", 32'(ram[71]), 15);
  endtask

  task automatic testVecAdd();
    localparam int N = 6;
    logic [15:0] av [N];
    logic [15:0] bv [N];
    doReset();
    for (int i = 0; i < N; i++) begin
      av[i] = 16'(3 + 7 * i);
      bv[i] = 16'(200 - 5 * i);
      poke(8'(16 + i), av[i]);
      poke(8'(48 + i), bv[i]);
    end
    poke(8'(16 + N), 16'h5555);
    rom[0] = iaddB(1, 8'd16);
    rom[1] = iaddB(2, 8'd16);
    rom[2] = iaddB(3, 8'd48);
    rom[3] = iaddB(0, 8'(N - 2));
    rom[4] = ld0B(4, 1, 1) | ld1B(5, 3, 1);
    rom[5] = addB(6, 4, 5) | ld0B(4, 1, 1) | ld1B(5, 3, 1);
    rom[6] = stB(6, 2, 1) | addB(6, 4, 5) | ld0B(4, 1, 1) | ld1B(5, 3, 1) | loopB(8'd6);
    rom[7] = stB(6, 2, 1) | addB(6, 4, 5);
    rom[8] = stB(6, 2, 1);
    runProg("R10");
    for (int i = 0; i < N; i++)
      chk("R10", $sformatf("sum element %0d", i), 32'(ram[16 + i]), 32'(16'(av[i] + bv[i])));
    chk("R10", "no store past the array", 32'(ram[16 + N]), 32'h5555);
    chk("R10", "each element read once", 32'(logN), 3 * N);
    repeat (5) @(negedge clk);
    chk("R2", "done held while halted", 32'(done), 1);
    chk("R2", "no request while halted", 32'(dmemReq), 0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2", "start restarts from address 0", 32'(imemAddr), 0);
    chk("R2", "done drops on restart", 32'(done), 0);
  endtask

  initial begin
    #3000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    testParallel();
    testLoadAdd();
    testMemOrder();
    testLoop();
    testVecAdd();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule